// File: doc/BRIEF.md
# Memory-to-Memory Three-Word Processor Core

This block is a small multicycle processor with no register file. Every instruction takes three consecutive words of one unified, word-addressed memory: an opcode, an address field and a value field. Every operand lives in that same memory. The stack also lives in it and grows downward from the highest word. The core keeps an instruction pointer, a stack pointer and an 8-bit flags register whose bit 0 is zero and bit 1 is negative. Words are two's complement and `DATA_W` bits wide. The memory holds `2**ADDR_W` words. Address and value fields are used modulo the memory size wherever they select a word.

A loader port writes any memory word at any time and takes priority over the core's own write. A peek port reads any word with one cycle of latency. A test environment holds the core in reset, loads a program and releases reset. It then waits for `halted_o` and inspects memory through the peek port.

The controller has seven states:
- `ST_FETCH_OP` reads the word at IP.
- `ST_FETCH_ADR` captures the opcode and reads IP+1.
- `ST_FETCH_VAL` captures the address field and reads IP+2.
- `ST_LATCH_VAL` captures the value field.
- `ST_EXEC` performs the instruction.
- `ST_WRITEBACK` finishes POP, INC and DEC, which need a memory read first.
- `ST_HALT` has no exit.

The transitions are:
- Each fetch state goes to the next one, and `ST_LATCH_VAL` goes to `ST_EXEC`.
- `ST_EXEC` goes to `ST_WRITEBACK` for POP, INC and DEC.
- `ST_EXEC` goes to `ST_HALT` for HLT or an illegal opcode.
- `ST_EXEC` goes to `ST_FETCH_OP` for every other opcode.
- `ST_WRITEBACK` always goes to `ST_FETCH_OP`.
- Hardware reset enters `ST_FETCH_OP`.

Top module: `mmcpu_core`

## Requirements
- R1: While reset is held, and on its release, IP equals `START_ADDR`, SP equals the last memory address, flags are 0, and `halted_o` and `trap_o` are 0. Reset does not change memory contents.
- R2: An instruction is the opcode at IP, the address field at IP+1 and the value field at IP+2. Opcodes are NOP=0, HLT=1, RST=2, DBG=3, LDI=4, PUSH=5, POP=6, JMP=7, JZ=8, CMP=9, INC=10 and DEC=11. Except where a rule below says otherwise, IP advances by 3 after an instruction. NOP and DBG change nothing else.
- R3: LDI writes the value field to memory[address] and sets the flags from that value. The flags are then 8'h00 plus bit 0 when the value is zero and bit 1 when its top bit is set. Flag bits 7..2 always read 0.
- R4: PUSH writes the value field to memory[SP] and then decrements SP. POP increments SP and then copies memory[SP] to memory[address]. Neither touches the flags. SP changes only by ±1 or by being reinitialised.
- R5: JMP sets IP to the address field. JZ does the same when flag bit 0 is 1, and otherwise advances IP by 3. A taken jump gets no extra +3.
- R6: CMP sets flag bit 0 when (address − value) mod 2^DATA_W is zero and clears it otherwise. It leaves flag bit 1 and memory unchanged.
- R7: INC and DEC read memory[address], add or subtract 1 with wraparound, write the result back, and set the flags from the result as in R3.
- R8: HLT sets `halted_o`, leaves IP on the HLT instruction, and stops all fetching. While halted, IP, SP and flags hold and the core writes no memory.
- R9: An opcode word above 11 sets `trap_o` and `halted_o` without writing memory. `trap_o` stays set until hardware reset.
- R10: RST sets IP to `START_ADDR` and SP to the last address, then execution continues from there. Memory and flags are preserved.
- R11: A write on the loader port stores `load_data` at `load_addr` on the clock edge. `peek_data` shows the word at `peek_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Loader write strobe |
| load_addr | input | ADDR_W | Loader write address |
| load_data | input | DATA_W | Loader write data |
| peek_addr | input | ADDR_W | Inspection read address |
| peek_data | output | DATA_W | Inspection read data, one cycle latency |
| ip_o | output | ADDR_W | Instruction pointer |
| sp_o | output | ADDR_W | Stack pointer |
| flags_o | output | 8 | Flags: bit 0 zero, bit 1 negative |
| halted_o | output | 1 | Core has stopped |
| trap_o | output | 1 | Sticky illegal-opcode indicator |

## Verification
The bench sweeps LDI, INC and DEC over single-bit values and the wrap points 0x0000, 0x7FFF, 0x8000 and 0xFFFF. A wrong carry or a wrong negative bit there shows up as a bad result word or bad flags. It crosses CMP over pairs taken from the extreme values after a negative load. A design that cleared the negative bit, or tested only the low bits of the difference, gives wrong flags. Jump programs place a sentinel three words beyond the target, so a taken jump that also advanced by 3 executes the wrong code. An RST program loops once through a PUSH and shows whether SP was reinitialised. A sweep of illegal opcodes checks that nothing is written and that the trap stays set.

// File: rtl/mmcpu_pkg.sv
package mmcpu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_HLT  = 4'd1,
        OP_RST  = 4'd2,
        OP_DBG  = 4'd3,
        OP_LDI  = 4'd4,
        OP_PUSH = 4'd5,
        OP_POP  = 4'd6,
        OP_JMP  = 4'd7,
        OP_JZ   = 4'd8,
        OP_CMP  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11
    } op_e;

    localparam int unsigned OP_COUNT = 12;

    typedef enum logic [2:0] {
        ST_FETCH_OP,
        ST_FETCH_ADR,
        ST_FETCH_VAL,
        ST_LATCH_VAL,
        ST_EXEC,
        ST_WRITEBACK,
        ST_HALT
    } state_e;

    localparam int unsigned FLAG_Z = 0;
    localparam int unsigned FLAG_N = 1;

endpackage

// File: rtl/mmcpu_mem.sv
module mmcpu_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata_a <= store[raddr_a];
        rdata_b <= store[raddr_b];
    end
endmodule

// File: rtl/mmcpu_alu.sv
module mmcpu_alu
    import mmcpu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] adr,
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        flags_out
);
    logic [DATA_W-1:0] diff;

    function automatic logic [7:0] nz_of(input logic [DATA_W-1:0] w);
        return {6'b0, w[DATA_W-1], (w == '0)};
    endfunction

    always_comb begin
        diff      = adr - val;
        result    = val;
        flags_out = flags_in;
        case (op)
            OP_LDI: begin
                result    = val;
                flags_out = nz_of(val);
            end
            OP_INC: begin
                result    = mem_word + DATA_W'(1);
                flags_out = nz_of(result);
            end
            OP_DEC: begin
                result    = mem_word - DATA_W'(1);
                flags_out = nz_of(result);
            end
            OP_CMP: begin
                flags_out = {6'b0, flags_in[FLAG_N], (diff == '0)};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmcpu_ctrl.sv
module mmcpu_ctrl
    import mmcpu_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned START_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ip_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [7:0]        flags_o,
    output logic              halted_o,
    output logic              trap_o
);
    localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);
    localparam logic [ADDR_W-1:0] TOP   = '1;
    localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(3);

    state_e            state_q, state_nx;
    logic [ADDR_W-1:0] ip_q, sp_q;
    logic [DATA_W-1:0] op_q, adr_q, val_q;
    logic [7:0]        flags_q;
    logic              halted_q, trap_q;

    op_e               op;
    logic              legal;
    logic [ADDR_W-1:0] adr_w;
    logic [DATA_W-1:0] alu_res;
    logic [7:0]        alu_flags;

    assign op    = op_e'(op_q[3:0]);
    assign legal = (op_q < DATA_W'(OP_COUNT));
    assign adr_w = adr_q[ADDR_W-1:0];

    mmcpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op),
        .adr      (adr_q),
        .val      (val_q),
        .mem_word (rdata),
        .flags_in (flags_q),
        .result   (alu_res),
        .flags_out(alu_flags)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_OP;
        else     state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FETCH_OP:  state_nx = ST_FETCH_ADR;
            ST_FETCH_ADR: state_nx = ST_FETCH_VAL;
            ST_FETCH_VAL: state_nx = ST_LATCH_VAL;
            ST_LATCH_VAL: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (!legal || op == OP_HLT)                          state_nx = ST_HALT;
                else if (op == OP_POP || op == OP_INC || op == OP_DEC) state_nx = ST_WRITEBACK;
                else                                                 state_nx = ST_FETCH_OP;
            end
            ST_WRITEBACK: state_nx = ST_FETCH_OP;
            ST_HALT:      state_nx = ST_HALT;
            default:      state_nx = ST_HALT;
        endcase
    end

    // Memory address and write port
    always_comb begin
        raddr = ip_q;
        we    = 1'b0;
        waddr = adr_w;
        wdata = alu_res;
        case (state_q)
            ST_FETCH_ADR: raddr = ip_q + ONE;
            ST_FETCH_VAL: raddr = ip_q + TWO;
            ST_EXEC: begin
                if (legal) begin
                    case (op)
                        OP_POP:         raddr = sp_q + ONE;
                        OP_INC, OP_DEC: raddr = adr_w;
                        OP_LDI: begin
                            we    = 1'b1;
                            waddr = adr_w;
                            wdata = val_q;
                        end
                        OP_PUSH: begin
                            we    = 1'b1;
                            waddr = sp_q;
                            wdata = val_q;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WRITEBACK: begin
                we    = 1'b1;
                waddr = adr_w;
                wdata = (op == OP_POP) ? rdata : alu_res;
            end
            default: ;
        endcase
    end

    // Architectural state
    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q     <= START;
            sp_q     <= TOP;
            flags_q  <= 8'h00;
            halted_q <= 1'b0;
            trap_q   <= 1'b0;
            op_q     <= '0;
            adr_q    <= '0;
            val_q    <= '0;
        end else begin
            case (state_q)
                ST_FETCH_ADR: op_q  <= rdata;
                ST_FETCH_VAL: adr_q <= rdata;
                ST_LATCH_VAL: val_q <= rdata;
                ST_EXEC: begin
                    if (!legal) begin
                        trap_q   <= 1'b1;
                        halted_q <= 1'b1;
                    end else begin
                        unique case (op)
                            OP_NOP, OP_DBG: ip_q <= ip_q + STEP;
                            OP_HLT:         halted_q <= 1'b1;
                            OP_RST: begin
                                ip_q <= START;
                                sp_q <= TOP;
                            end
                            OP_LDI, OP_CMP: begin
                                flags_q <= alu_flags;
                                ip_q    <= ip_q + STEP;
                            end
                            OP_PUSH: begin
                                sp_q <= sp_q - ONE;
                                ip_q <= ip_q + STEP;
                            end
                            OP_POP:         sp_q <= sp_q + ONE;
                            OP_JMP:         ip_q <= adr_w;
                            OP_JZ:          ip_q <= flags_q[FLAG_Z] ? adr_w : ip_q + STEP;
                            OP_INC, OP_DEC: ;
                        endcase
                    end
                end
                ST_WRITEBACK: begin
                    ip_q <= ip_q + STEP;
                    if (op == OP_INC || op == OP_DEC) flags_q <= alu_flags;
                end
                default: ;
            endcase
        end
    end

    assign ip_o     = ip_q;
    assign sp_o     = sp_q;
    assign flags_o  = flags_q;
    assign halted_o = halted_q;
    assign trap_o   = trap_q;
endmodule

// File: rtl/mmcpu_core.sv
module mmcpu_core #(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned START_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] ip_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [7:0]        flags_o,
    output logic              halted_o,
    output logic              trap_o
);
    logic              core_we;
    logic [ADDR_W-1:0] core_waddr, core_raddr;
    logic [DATA_W-1:0] core_wdata, core_rdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    assign mem_we    = load_en | core_we;
    assign mem_waddr = load_en ? load_addr : core_waddr;
    assign mem_wdata = load_en ? load_data : core_wdata;

    mmcpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr_a(core_raddr),
        .rdata_a(core_rdata),
        .raddr_b(peek_addr),
        .rdata_b(peek_data)
    );

    mmcpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rdata   (core_rdata),
        .raddr   (core_raddr),
        .we      (core_we),
        .waddr   (core_waddr),
        .wdata   (core_wdata),
        .ip_o    (ip_o),
        .sp_o    (sp_o),
        .flags_o (flags_o),
        .halted_o(halted_o),
        .trap_o  (trap_o)
    );
endmodule

// File: rtl/mmcpu_core_chk.sv
module mmcpu_core_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ip_o,
    input logic [ADDR_W-1:0] sp_o,
    input logic [7:0]        flags_o,
    input logic              halted_o,
    input logic              trap_o,
    input logic              core_we
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    AST_FLAGS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) flags_o[7:2] == 6'b0); // R3
    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        (sp_o != $past(sp_o)) |-> (sp_o == $past(sp_o) + ONE || sp_o == $past(sp_o) - ONE || sp_o == TOP)); // R4
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> ($stable(ip_o) && $stable(sp_o) && $stable(flags_o) && halted_o)); // R8
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) halted_o |-> !core_we); // R8
    AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (rst) trap_o |=> trap_o); // R9
    AST_TRAP_HALTS: assert property (@(posedge clk) disable iff (rst) trap_o |-> halted_o); // R9
endmodule

bind mmcpu_core mmcpu_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ip_o    (ip_o),
    .sp_o    (sp_o),
    .flags_o (flags_o),
    .halted_o(halted_o),
    .trap_o  (trap_o),
    .core_we (core_we)
);

// File: tb/mmcpu_core_bench.sv
`timescale 1ns/1ps
module mmcpu_core_bench;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam logic [15:0] NOP = 0, HLT = 1, RST = 2, DBG = 3, LDI = 4, PUSH = 5,
                            POP = 6, JMP = 7, JZ = 8, CMP = 9, INC = 10, DEC = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic [AW-1:0] ip_o, sp_o;
    logic [7:0] flags_o;
    logic halted_o, trap_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmcpu_core #(.DATA_W(DW), .ADDR_W(AW), .START_ADDR(0)) u_mmcpu_core (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .ip_o(ip_o), .sp_o(sp_o),
        .flags_o(flags_o), .halted_o(halted_o), .trap_o(trap_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nz(input logic [15:0] v);
        return {6'b0, v[15], (v == 16'h0000)};
    endfunction

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic ins(input logic [AW-1:0] base, input logic [15:0] op, input logic [15:0] a, input logic [15:0] v);
        put(base, op);
        put(base + AW'(1), a);
        put(base + AW'(2), v);
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        peek_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = peek_data;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input string tag);
        bit seen = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (halted_o) begin
                seen = 1'b1;
                break;
            end
        end
        check({tag, " halt reached"}, seen, 1'b1);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                  16'h8000, 16'h8001, 16'h00FF, 16'h1234};
        logic [15:0] cv [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};

        // R1 reset state and R11 loader/peek
        repeat (3) @(negedge clk);
        check("R1 ip", ip_o, 0);
        check("R1 sp", sp_o, 8'hFF);
        check("R1 flags", flags_o, 0);
        check("R1 halted", halted_o, 0);
        check("R1 trap", trap_o, 0);
        put(8'd200, 16'hBEEF);
        peek(8'd200, d);
        check("R11 peek after load", d, 16'hBEEF);

        // R3 LDI sweep
        for (int k = 0; k < 20; k++) begin
            logic [15:0] v;
            v = (k < 16) ? (16'h1 << k) : (k == 16 ? 16'h0 : (k == 17 ? 16'hFFFF : (k == 18 ? 16'h7FFF : 16'h1234)));
            hold_reset();
            ins(0, LDI, 100, v);
            ins(3, HLT, 0, 0);
            run("R3");
            peek(100, d);
            check("R3 ldi mem", d, v);
            check("R3 ldi flags", flags_o, nz(v));
            check("R8 ip on hlt", ip_o, 3);
        end

        // R7 INC/DEC sweep
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v, r;
            v = vals[k % 8];
            r = (k < 8) ? v + 16'd1 : v - 16'd1;
            hold_reset();
            put(100, v);
            ins(0, (k < 8) ? INC : DEC, 100, 0);
            ins(3, HLT, 0, 0);
            run("R7");
            peek(100, d);
            check("R7 incdec mem", d, r);
            check("R7 incdec flags", flags_o, nz(r));
            check("R2 ip advance", ip_o, 3);
        end

        // R6 CMP cross after a negative load
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                hold_reset();
                ins(0, LDI, 50, 16'h8000);
                ins(3, CMP, cv[i], cv[j]);
                ins(6, HLT, 0, 0);
                run("R6");
                check("R6 cmp flags", flags_o, {6'b0, 1'b1, (cv[i] == cv[j])});
                peek(50, d);
                check("R6 cmp mem", d, 16'h8000);
            end
        end

        // R4 push/pop
        hold_reset();
        ins(0, PUSH, 0, 16'h1111);
        ins(3, PUSH, 0, 16'h2222);
        ins(6, POP, 100, 0);
        ins(9, POP, 101, 0);
        ins(12, HLT, 0, 0);
        run("R4");
        check("R4 sp restored", sp_o, 8'hFF);
        peek(255, d); check("R4 stack top", d, 16'h1111);
        peek(254, d); check("R4 stack next", d, 16'h2222);
        peek(100, d); check("R4 pop first", d, 16'h2222);
        peek(101, d); check("R4 pop second", d, 16'h1111);
        check("R4 flags untouched", flags_o, 0);
        hold_reset();
        ins(0, PUSH, 0, 16'h3333);
        ins(3, HLT, 0, 0);
        run("R4b");
        check("R4 sp after push", sp_o, 8'hFE);

        // R5 JMP
        hold_reset();
        put(100, 16'hAAAA); put(101, 16'h0);
        ins(0, JMP, 9, 0);
        ins(3, LDI, 100, 1);
        ins(6, HLT, 0, 0);
        ins(9, LDI, 101, 7);
        ins(12, HLT, 0, 0);
        run("R5");
        peek(100, d); check("R5 jmp skipped", d, 16'hAAAA);
        peek(101, d); check("R5 jmp target ran", d, 7);
        check("R5 jmp ip", ip_o, 12);

        // R5 JZ taken and not taken
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            put(100, 16'hAAAA); put(101, 16'h0);
            ins(0, LDI, 60, (t == 0) ? 16'h0 : 16'h5);
            ins(3, JZ, 12, 0);
            ins(6, LDI, 100, 1);
            ins(9, HLT, 0, 0);
            ins(12, LDI, 101, 2);
            ins(15, HLT, 0, 0);
            run("R5jz");
            peek(100, d); check("R5 jz fallthrough word", d, (t == 0) ? 16'hAAAA : 16'h1);
            peek(101, d); check("R5 jz target word", d, (t == 0) ? 16'h2 : 16'h0);
            check("R5 jz ip", ip_o, (t == 0) ? 15 : 9);
        end

        // R2 NOP/DBG
        hold_reset();
        put(100, 16'h5A5A);
        ins(0, NOP, 100, 9);
        ins(3, DBG, 100, 5);
        ins(6, HLT, 0, 0);
        run("R2");
        peek(100, d); check("R2 nop dbg no write", d, 16'h5A5A);
        check("R2 nop dbg ip", ip_o, 6);
        check("R2 nop dbg flags", flags_o, 0);
        check("R2 nop dbg sp", sp_o, 8'hFF);

        // R8 halt stops fetching
        hold_reset();
        put(100, 16'h0042);
        ins(0, HLT, 0, 0);
        ins(3, LDI, 100, 9);
        run("R8");
        repeat (20) @(negedge clk);
        peek(100, d); check("R8 nothing after hlt", d, 16'h0042);
        check("R8 ip held", ip_o, 0);
        check("R8 still halted", halted_o, 1);

        // R10 RST instruction
        hold_reset();
        put(100, 16'hFFFE); put(255, 16'h0);
        ins(0, INC, 100, 0);
        ins(3, JZ, 12, 0);
        ins(6, PUSH, 0, 77);
        ins(9, RST, 0, 0);
        ins(12, HLT, 0, 0);
        run("R10");
        peek(100, d); check("R10 memory kept", d, 0);
        peek(255, d); check("R10 pushed word kept", d, 77);
        check("R10 sp reinit", sp_o, 8'hFF);
        check("R10 ip", ip_o, 12);
        check("R10 flags", flags_o, 8'h01);

        // R9 illegal opcode sweep
        for (int k = 0; k < 10; k++) begin
            logic [15:0] op;
            op = (k < 8) ? 16'(12 + k) : (k == 8 ? 16'h8000 : 16'hFFFF);
            hold_reset();
            put(100, 16'h0F0F);
            ins(0, op, 100, 5);
            run("R9");
            check("R9 trap set", trap_o, 1);
            repeat (5) @(negedge clk);
            check("R9 trap sticky", trap_o, 1);
            peek(100, d); check("R9 no write", d, 16'h0F0F);
            check("R9 ip", ip_o, 0);
        end
        hold_reset();
        check("R1 trap cleared by reset", trap_o, 0);
        check("R1 halted cleared by reset", halted_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule